// File: doc/BRIEF.md
# Interrupt Distributor Register File

This block is the distributor half of a small interrupt controller. It owns the per-interrupt configuration for a parameterised number of interrupt lines (64 by default): an enable bit, a priority, a processor-target mask and a trigger type. Software programs all of it over a simple 32-bit register bus. Writes take effect in a single cycle. Read data is registered and appears one cycle after the read.

The block samples the interrupt inputs and keeps a pending bit for each line. An edge-configured line becomes pending on a rising input and stays pending until acknowledged. A level-configured line is pending while its input is high. Each cycle the block picks, among the lines that are pending, enabled and targeted at processor 0, the most urgent one. A numerically lower priority is more urgent, and equal priorities go to the lower ID. The winner is presented on a registered ID/priority/valid port to a CPU interface. An acknowledge from that interface clears the pending state of an edge-triggered line.

Lines with IDs below 32 are private to processor 0. Their target and trigger fields are fixed and cannot be written. Addresses on the bus are word addresses. Each offset below is given as a byte offset, and the matching word address is that offset divided by four.

Top module: `irq_distributor`

## Requirements
- R1: Control register at byte offset 0x000, bit 0 is the global forward enable, reset 0. While it is 0, `cpu_irq_valid` stays low. Reads return the bit in bit 0.
- R2: Read-only type register at byte offset 0x004 returns NUM_IRQ/32-1 in bits [4:0] and NUM_CPU-1 in bits [7:5]. With the defaults (64 lines, 2 processors) it reads 0x00000021.
- R3: Set-enable words start at byte offset 0x100 and clear-enable words at 0x180. Bit b of word w is interrupt 32*w+b. Writing 1 sets or clears that enable, and writing 0 changes nothing. Both banks read back the current enables. All enables reset to 0.
- R4: Among candidates (pending, enabled, target bit 0 set, global enable on), the forwarded one has the numerically lowest priority. Ties go to the lowest ID.
- R5: Priority bytes start at byte offset 0x400, byte k of word w belonging to interrupt 4*w+k. Only the top PRIO_BITS bits (4 by default, bits [7:4]) are stored. Unstored bits read 0, so writing 0xFFFFFFFF reads back 0xF0F0F0F0. `cpu_irq_prio` uses the same 8-bit format.
- R6: Target bytes start at byte offset 0x800, laid out like priorities. Bit c selects processor c. Only bits below NUM_CPU are stored, so writing 0xFF reads 0x03. Only lines with bit 0 set are forwarded.
- R7: Trigger words start at byte offset 0xC00, two bits per interrupt. Bit 2k+1 of word w is 1 for edge-triggered and 0 for level-sensitive interrupt 16*w+k. Bit 2k always reads 0, so writing 0xFFFFFFFF reads 0xAAAAAAAA. All lines reset to level.
- R8: For IDs below 32, the target byte always reads 0x01 and the trigger bit always reads 0 (level). Writes to these fields are ignored.
- R9: An edge line becomes pending on a 0-to-1 input transition. It stays pending after the input falls, until `cpu_ack` with its ID. A level line is pending exactly while its input is high, and acknowledging it has no effect.
- R10: Reads of unimplemented word addresses return 0, and writes to them change no state.
- R11: The forwarded result is registered. A change of state at a clock edge (input sampled, register written, acknowledge taken) shows on `cpu_irq_*` after the following edge. When `cpu_irq_valid` is 0, the ID and priority outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 10 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_in | input | NUM_IRQ | Interrupt input lines |
| cpu_irq_valid | output | 1 | An interrupt is forwarded to processor 0 |
| cpu_irq_id | output | ID_W | ID of the forwarded interrupt |
| cpu_irq_prio | output | 8 | Its priority in 8-bit register format |
| cpu_ack | input | 1 | Acknowledge pulse from the CPU interface |
| cpu_ack_id | input | ID_W | ID being acknowledged |

## Verification
Read data is due one clock edge after the read is captured. Inputs are driven on falling edges. The monitor flags a read at the capturing rising edge and compares the queued expectation on the next falling edge. The forwarded ID/priority depends on two register stages: the pending or configuration state, then the output register. Each interrupt check therefore waits three rising edges after its last stimulus before sampling on a falling edge. That margin still fails if the design adds a further stage beyond it.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
   // word addresses of the register banks
   localparam int W_CTRL = 'h000;
   localparam int W_TYPE = 'h001;
   localparam int W_SEN  = 'h040;
   localparam int W_CEN  = 'h060;
   localparam int W_PRI  = 'h100;
   localparam int W_TGT  = 'h200;
   localparam int W_CFG  = 'h300;
   localparam int N_PRIV = 32;

   // place a stored priority in the top bits of an 8-bit field
   function automatic logic [7:0] prio_fmt(input logic [7:0] p, input int bits);
      return p << (8 - bits);
   endfunction
endpackage

// File: rtl/irqd_pending.sv
module irqd_pending #(
   parameter int NUM_IRQ = 64,
   parameter int ID_W    = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_in,
   input  logic [NUM_IRQ-1:0] edge_cfg,
   input  logic               ack,
   input  logic [ID_W-1:0]    ack_id,
   output logic [NUM_IRQ-1:0] pend
);
   for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
      logic prev_r, pend_r;
      logic rise, acked;
      assign rise  = irq_in[g] & ~prev_r;
      assign acked = ack && (ack_id == ID_W'(g));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prev_r <= 1'b0;
            pend_r <= 1'b0;
         end else begin
            prev_r <= irq_in[g];
            if (!edge_cfg[g])
               pend_r <= irq_in[g];
            else if (rise)
               pend_r <= 1'b1;
            else if (acked)
               pend_r <= 1'b0;
         end
      end
      assign pend[g] = pend_r;
   end
endmodule

// File: rtl/irqd_arbiter.sv
module irqd_arbiter #(
   parameter int NUM_IRQ   = 64,
   parameter int PRIO_BITS = 4,
   parameter int ID_W      = 10
) (
   input  logic [NUM_IRQ-1:0]                cand,
   input  logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio,
   output logic                              found,
   output logic [ID_W-1:0]                   best_id,
   output logic [PRIO_BITS-1:0]              best_prio
);
   always_comb begin
      found     = 1'b0;
      best_id   = '0;
      best_prio = '0;
      // ascending scan with strict compare keeps the lowest ID on ties
      for (int i = 0; i < NUM_IRQ; i++) begin
         if (cand[i] && (!found || prio[i] < best_prio)) begin
            found     = 1'b1;
            best_id   = ID_W'(i);
            best_prio = prio[i];
         end
      end
   end
endmodule

// File: rtl/irqd_regs.sv
module irqd_regs
   import irqd_pkg::*;
#(
   parameter int NUM_IRQ   = 64,
   parameter int NUM_CPU   = 2,
   parameter int PRIO_BITS = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              bus_sel,
   input  logic                              bus_wr,
   input  logic [9:0]                        bus_waddr,
   input  logic [31:0]                       bus_wdata,
   output logic [31:0]                       bus_rdata,
   output logic                              glob_en,
   output logic [NUM_IRQ-1:0]                en_q,
   output logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio_q,
   output logic [NUM_IRQ-1:0]                tgt_cpu0,
   output logic [NUM_IRQ-1:0]                edge_cfg
);
   localparam int LINES_M1 = NUM_IRQ / 32 - 1;
   localparam int CPUS_M1  = NUM_CPU - 1;

   logic wr;
   logic [31:0] rd;
   logic [NUM_IRQ-1:0][NUM_CPU-1:0] tgt_q;

   assign wr = bus_sel & bus_wr;

   always_ff @(posedge clk) begin
      if (!rst_n)
         glob_en <= 1'b0;
      else if (wr && bus_waddr == 10'(W_CTRL))
         glob_en <= bus_wdata[0];
   end

   for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
      localparam int EW = g / 32;
      localparam int EB = g % 32;
      localparam int PW = g / 4;
      localparam int PB = (g % 4) * 8;
      localparam int CW = g / 16;
      localparam int CB = (g % 16) * 2 + 1;
      logic en_r;
      logic [PRIO_BITS-1:0] pr_r;

      always_ff @(posedge clk) begin
         if (!rst_n)
            en_r <= 1'b0;
         else if (wr && bus_waddr == 10'(W_SEN + EW) && bus_wdata[EB])
            en_r <= 1'b1;
         else if (wr && bus_waddr == 10'(W_CEN + EW) && bus_wdata[EB])
            en_r <= 1'b0;
      end

      always_ff @(posedge clk) begin
         if (!rst_n)
            pr_r <= '0;
         else if (wr && bus_waddr == 10'(W_PRI + PW))
            pr_r <= bus_wdata[PB+7 -: PRIO_BITS];
      end

      assign en_q[g]   = en_r;
      assign prio_q[g] = pr_r;

      if (g < N_PRIV) begin : g_priv
         // private lines: fixed to processor 0, level-sensitive
         assign tgt_q[g]    = NUM_CPU'(1);
         assign edge_cfg[g] = 1'b0;
      end else begin : g_shared
         logic [NUM_CPU-1:0] tg_r;
         logic ed_r;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               tg_r <= '0;
               ed_r <= 1'b0;
            end else begin
               if (wr && bus_waddr == 10'(W_TGT + PW))
                  tg_r <= bus_wdata[PB +: NUM_CPU];
               if (wr && bus_waddr == 10'(W_CFG + CW))
                  ed_r <= bus_wdata[CB];
            end
         end
         assign tgt_q[g]    = tg_r;
         assign edge_cfg[g] = ed_r;
      end

      assign tgt_cpu0[g] = tgt_q[g][0];
   end

   always_comb begin
      rd = '0;
      if (bus_waddr == 10'(W_CTRL)) rd[0] = glob_en;
      if (bus_waddr == 10'(W_TYPE)) rd[7:0] = {3'(CPUS_M1), 5'(LINES_M1)};
      for (int i = 0; i < NUM_IRQ; i++) begin
         if (bus_waddr == 10'(W_SEN + i / 32) || bus_waddr == 10'(W_CEN + i / 32))
            rd[i % 32] = en_q[i];
         if (bus_waddr == 10'(W_PRI + i / 4))
            rd[(i % 4) * 8 +: 8] = prio_fmt(8'(prio_q[i]), PRIO_BITS);
         if (bus_waddr == 10'(W_TGT + i / 4))
            rd[(i % 4) * 8 +: 8] = 8'(tgt_q[i]);
         if (bus_waddr == 10'(W_CFG + i / 16))
            rd[(i % 16) * 2 + 1] = edge_cfg[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         bus_rdata <= '0;
      else if (bus_sel && !bus_wr)
         bus_rdata <= rd;
      else
         bus_rdata <= '0;
   end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
   import irqd_pkg::*;
#(
   parameter int NUM_IRQ   = 64,
   parameter int NUM_CPU   = 2,
   parameter int PRIO_BITS = 4,
   parameter int ID_W      = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [9:0]         bus_waddr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [NUM_IRQ-1:0] irq_in,
   output logic               cpu_irq_valid,
   output logic [ID_W-1:0]    cpu_irq_id,
   output logic [7:0]         cpu_irq_prio,
   input  logic               cpu_ack,
   input  logic [ID_W-1:0]    cpu_ack_id
);
   if (NUM_IRQ < 32 || NUM_IRQ > 1024 || NUM_IRQ % 32 != 0) begin : g_bad_irq
      $error("NUM_IRQ must be a multiple of 32 between 32 and 1024");
   end
   if (NUM_CPU < 1 || NUM_CPU > 8) begin : g_bad_cpu
      $error("NUM_CPU must be between 1 and 8");
   end
   if (PRIO_BITS < 1 || PRIO_BITS > 8) begin : g_bad_prio
      $error("PRIO_BITS must be between 1 and 8");
   end
   if ((1 << ID_W) < NUM_IRQ) begin : g_bad_id
      $error("ID_W too narrow for NUM_IRQ");
   end

   logic                              glob_en;
   logic [NUM_IRQ-1:0]                en_q, tgt_cpu0, edge_cfg, pend, cand;
   logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio_q;
   logic                              found;
   logic [ID_W-1:0]                   best_id;
   logic [PRIO_BITS-1:0]              best_prio;

   irqd_regs #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .PRIO_BITS(PRIO_BITS)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .glob_en(glob_en), .en_q(en_q), .prio_q(prio_q),
      .tgt_cpu0(tgt_cpu0), .edge_cfg(edge_cfg)
   );

   irqd_pending #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) u_pend (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .edge_cfg(edge_cfg),
      .ack(cpu_ack), .ack_id(cpu_ack_id), .pend(pend)
   );

   assign cand = pend & en_q & tgt_cpu0 & {NUM_IRQ{glob_en}};

   irqd_arbiter #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .ID_W(ID_W)) u_arb (
      .cand(cand), .prio(prio_q), .found(found),
      .best_id(best_id), .best_prio(best_prio)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpu_irq_valid <= 1'b0;
         cpu_irq_id    <= '0;
         cpu_irq_prio  <= '0;
      end else begin
         cpu_irq_valid <= found;
         cpu_irq_id    <= found ? best_id : '0;
         cpu_irq_prio  <= found ? prio_fmt(8'(best_prio), PRIO_BITS) : 8'h00;
      end
   end
endmodule

// File: rtl/irqd_checker.sv
module irqd_checker #(
   parameter int NUM_IRQ   = 64,
   parameter int PRIO_BITS = 4,
   parameter int ID_W      = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_sel,
   input logic               bus_wr,
   input logic [9:0]         bus_waddr,
   input logic [31:0]        bus_rdata,
   input logic               cpu_irq_valid,
   input logic [ID_W-1:0]    cpu_irq_id,
   input logic [7:0]         cpu_irq_prio,
   input logic               cpu_ack,
   input logic [ID_W-1:0]    cpu_ack_id,
   input logic               glob_en,
   input logic [NUM_IRQ-1:0] pend,
   input logic [NUM_IRQ-1:0] edge_cfg
);
   localparam logic [7:0] LOW_MASK = 8'((9'h100 >> PRIO_BITS) - 9'h1);

   logic [NUM_IRQ-1:0] ack_mask;
   assign ack_mask = cpu_ack ? (NUM_IRQ'(1) << cpu_ack_id) : '0;

   assert_glob_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_en |=> !cpu_irq_valid);

   assert_id_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq_valid |-> (int'(cpu_irq_id) < NUM_IRQ));

   assert_prio_lsb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq_valid |-> ((cpu_irq_prio & LOW_MASK) == 8'h00));

   assert_edge_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(pend & edge_cfg & ~ack_mask) & edge_cfg & ~pend) == '0));

   assert_priv_tgt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_waddr == 10'h200) |=> (bus_rdata == 32'h01010101));

   assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_irq_valid |-> (cpu_irq_id == '0 && cpu_irq_prio == 8'h00));
endmodule

bind irq_distributor irqd_checker #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .ID_W(ID_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_waddr(bus_waddr), .bus_rdata(bus_rdata),
   .cpu_irq_valid(cpu_irq_valid), .cpu_irq_id(cpu_irq_id), .cpu_irq_prio(cpu_irq_prio),
   .cpu_ack(cpu_ack), .cpu_ack_id(cpu_ack_id),
   .glob_en(glob_en), .pend(pend), .edge_cfg(edge_cfg)
);

// File: tb/tb_irq_distributor.sv
module tb_irq_distributor;
   localparam int N  = 64;
   localparam int IW = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_sel = 1'b0, bus_wr = 1'b0;
   logic [9:0] bus_waddr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [N-1:0] irq_in = '0;
   logic cpu_irq_valid;
   logic [IW-1:0] cpu_irq_id;
   logic [7:0] cpu_irq_prio;
   logic cpu_ack = 1'b0;
   logic [IW-1:0] cpu_ack_id = '0;

   int checks = 0;
   int errors = 0;

   typedef struct { logic [31:0] exp; string tag; } rd_item_t;
   rd_item_t sb[$];
   logic rd_seen = 1'b0;

   always #10 clk = ~clk;

   irq_distributor dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_in(irq_in), .cpu_irq_valid(cpu_irq_valid), .cpu_irq_id(cpu_irq_id),
      .cpu_irq_prio(cpu_irq_prio), .cpu_ack(cpu_ack), .cpu_ack_id(cpu_ack_id)
   );

   // monitor: a read captured at a rising edge is compared at the next falling edge
   always @(posedge clk) rd_seen <= bus_sel && !bus_wr;
   always @(negedge clk) begin
      if (rd_seen) begin
         rd_item_t it;
         it = sb.pop_front();
         checks++;
         if (bus_rdata !== it.exp) begin
            errors++;
            $display("FAIL %s: rdata=%08h expected=%08h", it.tag, bus_rdata, it.exp);
         end
      end
   end

   task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [9:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_waddr = a;
      sb.push_back('{exp: e, tag: tag});
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic check_irq(input logic v, input int id, input logic [7:0] p, input string tag);
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (cpu_irq_valid !== v || (v && (int'(cpu_irq_id) != id || cpu_irq_prio !== p))) begin
         errors++;
         $display("FAIL %s: valid=%0b id=%0d prio=%02h expected valid=%0b id=%0d prio=%02h",
                  tag, cpu_irq_valid, cpu_irq_id, cpu_irq_prio, v, id, p);
      end
   endtask

   task automatic set_irq(input int i, input logic v);
      @(negedge clk);
      irq_in[i] = v;
   endtask

   task automatic ack(input int i);
      @(negedge clk);
      cpu_ack = 1'b1; cpu_ack_id = IW'(i);
      @(negedge clk);
      cpu_ack = 1'b0;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(20 * 100000);
      errors++;
      $display("FAIL watchdog: run did not complete");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state
      check_irq(1'b0, 0, 8'h00, "R11 reset idle");
      bus_read(10'h000, 32'h0, "R1 ctrl reset");
      bus_read(10'h001, 32'h00000021, "R2 type register");
      bus_read(10'h041, 32'h0, "R3 enable reset");
      // enable banks
      bus_write(10'h040, 32'h5);
      bus_read(10'h040, 32'h5, "R3 set-enable readback");
      bus_read(10'h060, 32'h5, "R3 clear bank readback");
      bus_write(10'h060, 32'h1);
      bus_read(10'h040, 32'h4, "R3 clear one bit");
      bus_write(10'h060, 32'h0);
      bus_read(10'h040, 32'h4, "R3 write zero no effect");
      // priority format
      bus_write(10'h100, 32'hFFFFFFFF);
      bus_read(10'h100, 32'hF0F0F0F0, "R5 low prio bits zero");
      // targets
      bus_write(10'h200, 32'h0);
      bus_read(10'h200, 32'h01010101, "R8 private target fixed");
      bus_write(10'h208, 32'hFFFFFFFF);
      bus_read(10'h208, 32'h03030303, "R6 target width");
      bus_write(10'h208, 32'h02010101);
      bus_write(10'h20A, 32'h00000001);
      // trigger type
      bus_write(10'h300, 32'hFFFFFFFF);
      bus_read(10'h300, 32'h0, "R8 private config fixed");
      bus_write(10'h302, 32'hFFFFFFFF);
      bus_read(10'h302, 32'hAAAAAAAA, "R7 config upper bit only");
      bus_write(10'h302, 32'h00020000);
      // unimplemented space
      bus_write(10'h0C0, 32'hFFFFFFFF);
      bus_read(10'h0C0, 32'h0, "R10 unimplemented read");
      bus_read(10'h042, 32'h0, "R10 beyond last enable word");
      bus_read(10'h040, 32'h4, "R10 stray write left state");
      // priorities and enables for the forwarding tests
      bus_write(10'h108, 32'h00404000);
      bus_write(10'h10A, 32'h00000020);
      bus_write(10'h041, 32'h0000010E);
      bus_read(10'h061, 32'h0000010E, "R3 word 1 enables");
      // forwarding
      set_irq(33, 1'b1);
      check_irq(1'b0, 0, 8'h00, "R1 global enable off");
      bus_write(10'h000, 32'h1);
      bus_read(10'h000, 32'h1, "R1 ctrl readback");
      check_irq(1'b1, 33, 8'h40, "R4 single level line");
      set_irq(35, 1'b1);
      check_irq(1'b1, 33, 8'h40, "R6 line not targeted at cpu0");
      set_irq(34, 1'b1);
      check_irq(1'b1, 33, 8'h40, "R4 tie goes to lowest id");
      set_irq(40, 1'b1);
      set_irq(40, 1'b0);
      check_irq(1'b1, 40, 8'h20, "R9 edge latched after input falls");
      check_irq(1'b1, 40, 8'h20, "R9 edge still pending");
      ack(40);
      check_irq(1'b1, 33, 8'h40, "R9 ack clears edge");
      ack(33);
      check_irq(1'b1, 33, 8'h40, "R9 ack no effect on level");
      bus_write(10'h061, 32'h2);
      check_irq(1'b1, 34, 8'h40, "R3 cleared enable stops forwarding");
      set_irq(34, 1'b0);
      check_irq(1'b0, 0, 8'h00, "R9 level follows input");
      bus_write(10'h000, 32'h0);
      set_irq(40, 1'b1);
      check_irq(1'b0, 0, 8'h00, "R1 disabled blocks edge line");
      bus_write(10'h000, 32'h1);
      check_irq(1'b1, 40, 8'h20, "R9 edge held while disabled");
      repeat (3) @(negedge clk);
      summary();
   end
endmodule